// File: doc/BRIEF.md
# Gated/Continuous Memory Clock Generator

This block derives the clock for an external synchronous memory by integer division of the system clock. The divided clock can run in two ways. In gated mode it toggles only while the transaction sequencer reports that a synchronous transfer is in progress. In free-running mode it toggles all the time, for asynchronous and synchronous accesses alike. Free-running mode is honoured only while bank 1 is configured for synchronous operation.

The output changes state only at period boundaries. A clock that starts or stops therefore never produces a shortened high or low phase. A new divide ratio also waits for the next period boundary. When the clock is gated off, it rests low.

Along with the clock, the block drives two single-cycle strobes, one on each rising edge and one on each falling edge. The sequencer uses them to launch and capture data in step with the memory clock. All outputs come from registers clocked by the system clock.

Top module: `mclk_gen`

## Requirements
- R1: While rst_ni is low, mclk_o, mclk_rise_o and mclk_fall_o are all 0.
- R2: When neither txn_active_i nor the free-running condition has been high at a period boundary, mclk_o stays 0 and neither strobe fires.
- R3: The code on div_code_i gives a period of N = div_code_i + 1 system-clock cycles. Within each period mclk_o is high for floor(N/2) cycles, followed by N - floor(N/2) low cycles.
- R4: The code 0 on div_code_i is treated as code 1, which gives N = 2.
- R5: In gated mode, if txn_active_i is high at a clock edge while the generator is idle, mclk_o goes high at that same edge. Each later period starts at the edge where the previous period ends, provided txn_active_i is still high at that edge.
- R6: If the run request drops in the middle of a period, the period completes unchanged and mclk_o then stays 0. Starting and stopping happen only at period boundaries.
- R7: With cont_en_i = 1 and bank1_sync_i = 1, the clock runs continuously even while txn_active_i = 0.
- R8: With cont_en_i = 1 and bank1_sync_i = 0, the free-running request is ignored, so with txn_active_i = 0 no clock is produced.
- R9: div_code_i is sampled only at the edge that starts a period. A change made in the middle of a period first takes effect in the following period.
- R10: mclk_rise_o is 1 exactly in the cycles where mclk_o has just gone from 0 to 1. mclk_fall_o is 1 exactly in the cycles where mclk_o has just gone from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_code_i | input | DIV_W | Divide code, period = code + 1 cycles (0 acts as 1) |
| cont_en_i | input | 1 | Free-running clock enable |
| bank1_sync_i | input | 1 | Bank 1 configured for synchronous mode |
| txn_active_i | input | 1 | Synchronous transaction in progress |
| mclk_o | output | 1 | Divided memory clock |
| mclk_rise_o | output | 1 | Strobe marking a rising edge of mclk_o |
| mclk_fall_o | output | 1 | Strobe marking a falling edge of mclk_o |

## Verification
The assertions check four properties on every cycle:
- each strobe coincides with the matching transition of mclk_o;
- the high phase that ends at each falling edge lasts exactly half the period in force;
- the period counter never passes the latched terminal count;
- an idle generator with no request keeps the clock low.

Other properties can only be shown by the directed scenarios, because they depend on the exact cycle-by-cycle waveform:
- the full period and the low-phase length for each ratio;
- the rising edge appearing at the same edge that sees a new request;
- a stop in mid-period completing the period;
- a ratio change being deferred to the next period;
- free-running mode being ignored while bank 1 is asynchronous.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } mclk_edge_t;

endpackage

// File: rtl/mclk_ratio_sel.sv
module mclk_ratio_sel #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic             load_i,
  output logic [DIV_W-1:0] last_idx_o,
  output logic [DIV_W-1:0] half_o
);

  localparam logic [DIV_W-1:0] MIN_CODE = DIV_W'(1);

  logic [DIV_W-1:0] last_q;
  logic [DIV_W:0]   n_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= MIN_CODE;
    end else if (load_i) begin
      last_q <= (div_code_i == '0) ? MIN_CODE : div_code_i;
    end
  end

  assign n_ext      = {1'b0, last_q} + 1'b1;
  assign last_idx_o = last_q;
  assign half_o     = n_ext[DIV_W:1];

endmodule

// File: rtl/mclk_phase_ctr.sv
module mclk_phase_ctr #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             want_i,
  input  logic [DIV_W-1:0] last_idx_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             load_o,
  output logic             level_d_o,
  output logic             busy_o
);

  logic             run_q, run_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] cnt_inc;
  logic             boundary;

  assign cnt_inc  = cnt_q + 1'b1;
  assign boundary = !run_q || (cnt_q == last_idx_i);
  assign load_o   = boundary && want_i;

  always_comb begin
    run_d     = run_q;
    cnt_d     = cnt_q;
    level_d_o = 1'b0;
    if (boundary) begin
      cnt_d     = '0;
      run_d     = want_i;
      level_d_o = want_i;
    end else begin
      cnt_d     = cnt_inc;
      level_d_o = (cnt_inc < half_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = run_q;

  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= last_idx_i));

endmodule

// File: rtl/mclk_out_stage.sv
module mclk_out_stage
  import mclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       level_d_i,
  output mclk_edge_t edge_o
);

  mclk_edge_t out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
    end else begin
      out_q.level <= level_d_i;
      out_q.rise  <= level_d_i & ~out_q.level;
      out_q.fall  <= ~level_d_i & out_q.level;
    end
  end

  assign edge_o = out_q;

  assert_rise_marks_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q.rise |-> (out_q.level && !$past(out_q.level)));

  assert_fall_marks_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q.fall |-> (!out_q.level && $past(out_q.level)));

endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
  import mclk_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic             cont_en_i,
  input  logic             bank1_sync_i,
  input  logic             txn_active_i,
  output logic             mclk_o,
  output logic             mclk_rise_o,
  output logic             mclk_fall_o
);

  logic             want;
  logic             load;
  logic             level_d;
  logic             busy;
  logic [DIV_W-1:0] last_idx;
  logic [DIV_W-1:0] half;
  mclk_edge_t       edge_s;

  // free-running request only counts while bank 1 is synchronous
  assign want = txn_active_i | (cont_en_i & bank1_sync_i);

  mclk_ratio_sel #(.DIV_W(DIV_W)) u_ratio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_code_i (div_code_i),
    .load_i     (load),
    .last_idx_o (last_idx),
    .half_o     (half)
  );

  mclk_phase_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .want_i     (want),
    .last_idx_i (last_idx),
    .half_i     (half),
    .load_o     (load),
    .level_d_o  (level_d),
    .busy_o     (busy)
  );

  mclk_out_stage u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_d_i (level_d),
    .edge_o    (edge_s)
  );

  assign mclk_o      = edge_s.level;
  assign mclk_rise_o = edge_s.rise;
  assign mclk_fall_o = edge_s.fall;

  // high-phase length tracker for the checks below
  logic [DIV_W-1:0] chk_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_hi_q <= '0;
    end else if (mclk_o) begin
      chk_hi_q <= mclk_rise_o ? DIV_W'(1) : chk_hi_q + 1'b1;
    end
  end

  assert_high_phase_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_fall_o |-> (chk_hi_q == half));

  assert_idle_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(want) && !$past(busy)) |-> !mclk_o);

endmodule

// File: tb/mclk_gen_tb_top.sv
module mclk_gen_tb_top;

  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] div_code = '0;
  logic             cont_en = 1'b0;
  logic             bank1_sync = 1'b0;
  logic             txn = 1'b0;
  logic             mclk, rise, fall;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mclk_gen #(.DIV_W(DIV_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .div_code_i   (div_code),
    .cont_en_i    (cont_en),
    .bank1_sync_i (bank1_sync),
    .txn_active_i (txn),
    .mclk_o       (mclk),
    .mclk_rise_o  (rise),
    .mclk_fall_o  (fall)
  );

  task automatic chk(input string tag, input int idx, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s idx=%0d actual=%0b expected=%0b", tag, idx, act, exp);
    end
  endtask

  task automatic settle_idle();
    txn = 1'b0; cont_en = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  // mode 0: transaction strobe, mode 1: free-running (sync bank)
  // request held for edges 0..w-1; periods start at k*N while k*N < w
  task automatic run_case(input string tag, input int code, input int mode,
                          input int w, input int total);
    int n, h;
    n = (code == 0) ? 2 : code + 1;
    h = n / 2;
    @(negedge clk);
    div_code = DIV_W'(code);
    bank1_sync = 1'b1;
    if (mode == 0) txn = 1'b1; else cont_en = 1'b1;
    for (int i = 0; i < total; i++) begin
      int  p, k;
      logic on;
      @(posedge clk); #1;
      k = i / n; p = i % n;
      on = (k * n) < w;
      chk({tag, " level"}, i, mclk, on && (p < h));
      chk({tag, " R10 rise"}, i, rise, on && (p == 0));
      chk({tag, " R10 fall"}, i, fall, on && (p == h));
      @(negedge clk);
      if (i + 1 == w) begin txn = 1'b0; cont_en = 1'b0; end
    end
    settle_idle();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 mclk", 0, mclk, 1'b0);
    chk("R1 rise", 0, rise, 1'b0);
    chk("R1 fall", 0, fall, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 mclk held", 1, mclk, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      chk("R2 idle mclk", i, mclk, 1'b0);
      chk("R2 idle rise", i, rise, 1'b0);
    end
  endtask

  task automatic t_gated_ratios();
    run_case("R3 R5 N4", 3, 0, 12, 20);
    run_case("R3 N3", 2, 0, 9, 15);
    run_case("R3 N16", 15, 0, 32, 40);
    run_case("R4 code0", 0, 0, 6, 10);
  endtask

  task automatic t_stop_mid();
    run_case("R6 stop N4", 3, 0, 6, 14);
    run_case("R6 stop N5", 4, 0, 1, 10);
  endtask

  task automatic t_continuous();
    run_case("R7 cont N6", 5, 1, 18, 26);
  endtask

  task automatic t_cont_async();
    @(negedge clk);
    div_code = 4'd3; cont_en = 1'b1; bank1_sync = 1'b0; txn = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R8 mclk", i, mclk, 1'b0);
      chk("R8 rise", i, rise, 1'b0);
    end
    settle_idle();
  endtask

  task automatic t_ratio_change();
    logic exp_l;
    @(negedge clk);
    div_code = 4'd3; bank1_sync = 1'b1; txn = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      exp_l = (i < 4) ? (i < 2) : ((i - 4) < 4);
      chk("R9 level", i, mclk, exp_l);
      chk("R9 rise", i, rise, (i == 0) || (i == 4));
      @(negedge clk);
      if (i == 1) div_code = 4'd7;
      if (i == 11) txn = 1'b0;
    end
    settle_idle();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_gated_ratios();
    t_stop_mid();
    t_continuous();
    t_cont_async();
    t_ratio_change();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule